// File: doc/BRIEF.md
# Local Trigger Pulse Generator

This block produces local level-1 accept pulses aligned to a bunch-crossing timebase. An internal crossing counter advances once per crossing enable and wraps at the orbit length. Each accept is a single-clock pulse that follows the crossing on which it was decided.

A configuration word selects how accepts are spaced: once every N+1 orbits at a fixed crossing slot, once every N+1 crossings, or at pseudo-random spacing with a mean rate proportional to N. A burst command releases a counted number of accepts. A continuous command keeps accepts flowing until it is stopped. A selectable group of sliding-window spacing rules can hold back an accept. A held-back accept is deferred to the next crossing the rules allow, so no accept is lost.

Top module: `ltrig_gen`

## Requirements
- R1: After the synchronous reset `l1a` and `cont_on` are 0. No accept appears until a start command is given.
- R2: `cmd_burst` given while `cont_on` is 0 starts a burst of exactly `cfg_burst`+1 accepts (a field of 0 gives one accept). Generation then stops.
- R3: With `cfg_mode` = 2'b10 a request is raised on the first crossing after the start command and then every `cfg_rate`+1 crossings. When no rule holds them back, the accepts fall on exactly those crossings.
- R4: With `cfg_mode` = 2'b00 a request is raised at crossing index `ORBIT_SLOT` of the first orbit slot after the start command and then every `cfg_rate`+1 orbits. No spacing rule applies in this mode.
- R5: With `cfg_mode` = 2'b11 a 32-bit LFSR is drawn once per crossing. A request is raised when the draw is below `cfg_rate` x 2^33 / `BX_RATE`, and the spacing rules apply.
- R6: The spacing rules are rule 1: at most 1 accept in any 3 consecutive crossings; rule 2: at most 2 in 25; rule 3: at most 3 in 100; rule 4: at most 4 in 240. `cfg_rules` 2'b00 enables rules 1 to 4, 2'b01 rules 1 to 3, 2'b10 rules 1 and 2, and 2'b11 rule 1 only. The rules apply in random mode, and in crossing mode when `cfg_rate` < 63. A request that a rule holds back stays pending until the first allowed crossing. A request that arrives while one is pending merges with it.
- R7: `cmd_cont` sets `cont_on` in the next cycle, and accepts continue with no count limit.
- R8: `cmd_burst` given while `cont_on` is 1 only clears `cont_on`. No further accept follows and no burst starts.
- R9: `cmd_reset` clears `cont_on` and stops any burst or continuous run.
- R10: `cfg_mode` = 2'b01 produces no accepts.
- R11: The crossing counter advances only on `bx_en` and wraps at `ORBIT_LEN`. `l1a` is high for one clock only, in the cycle after a `bx_en` cycle.
- R12: Commands given in the same cycle take effect in the order reset, then burst, then continuous. No accept is decided in a cycle that carries a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_en | input | 1 | One bunch crossing per high cycle |
| cfg_mode | input | 2 | Spacing mode: 00 orbit, 10 crossing, 11 random, 01 idle |
| cfg_rules | input | 2 | Spacing-rule group selection |
| cfg_burst | input | 12 | Accepts per burst minus one |
| cfg_rate | input | 16 | Rate value N |
| cmd_burst | input | 1 | Start-burst / stop-continuous strobe |
| cmd_cont | input | 1 | Start-continuous strobe |
| cmd_reset | input | 1 | General reset strobe for generation |
| l1a | output | 1 | One-cycle accept pulse |
| cont_on | output | 1 | Continuous generation is running |

## Verification
The bench builds the block with `ORBIT_LEN` = 50 and `ORBIT_SLOT` = 7. This lets orbit mode with a multi-orbit period, and a counter wrap under randomly gated crossings, finish within a few hundred crossings. `BX_RATE` keeps its default, so random mode with N near its maximum gives an accept roughly every few hundred crossings. Over that span all four rule windows can bite and be checked on the recorded accept times.

// File: rtl/ltg_pkg.sv
package ltg_pkg;

    typedef enum logic [1:0] {
        MODE_ORBIT = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_BX    = 2'b10,
        MODE_RAND  = 2'b11
    } ltg_mode_e;

    typedef struct packed {
        ltg_mode_e   mode;
        logic [1:0]  rules;
        logic [11:0] burst;
        logic [15:0] rate;
    } ltg_cfg_t;

    localparam int RULE_N = 4;
    localparam logic [15:0] RULE_RATE_LIMIT = 16'd63;

    // Window length in crossings of spacing rule i (rule i allows i+1 accepts)
    function automatic int rule_window(input int i);
        case (i)
            0:       return 3;
            1:       return 25;
            2:       return 100;
            default: return 240;
        endcase
    endfunction

    function automatic logic rules_apply(input ltg_cfg_t c);
        return (c.mode == MODE_RAND) ||
               ((c.mode == MODE_BX) && (c.rate < RULE_RATE_LIMIT));
    endfunction

endpackage

// File: rtl/ltg_timebase.sv
module ltg_timebase #(
    parameter int ORBIT_LEN = 3564,
    parameter int IDX_W     = $clog2(ORBIT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bx_en,
    output logic [IDX_W-1:0] bx_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ORBIT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)
            bx_idx <= '0;
        else if (bx_en)
            bx_idx <= (bx_idx == LAST) ? '0 : bx_idx + 1'b1;
    end

    a_r11_idx_range: assert property (@(posedge clk) disable iff (rst)
        bx_idx <= LAST);

endmodule

// File: rtl/ltg_req_src.sv
module ltg_req_src
    import ltg_pkg::*;
#(
    parameter int ORBIT_LEN  = 3564,
    parameter int ORBIT_SLOT = 500,
    parameter int BX_RATE    = 40_000_000,
    parameter int IDX_W      = $clog2(ORBIT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bx_en,
    input  logic             restart,
    input  ltg_mode_e        mode,
    input  logic [15:0]      rate,
    input  logic [IDX_W-1:0] bx_idx,
    output logic             req
);
    localparam logic [47:0] RAND_SCALE = 48'((64'd1 << 33) / BX_RATE);
    localparam logic [31:0] LFSR_SEED  = 32'h1D87_2B41;
    localparam logic [31:0] LFSR_MASK  = 32'hB4BC_D35C;

    logic [15:0] gap_q, orb_q;
    logic [31:0] lfsr_q;
    logic [47:0] thr;
    logic        at_slot, hit;

    always_comb begin
        thr     = 48'(rate) * RAND_SCALE;
        hit     = (thr[47:32] != '0) || (lfsr_q < thr[31:0]);
        at_slot = (bx_idx == IDX_W'(ORBIT_SLOT));
        case (mode)
            MODE_ORBIT: req = at_slot && (orb_q == '0);
            MODE_BX:    req = (gap_q == '0);
            MODE_RAND:  req = hit;
            default:    req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            orb_q  <= '0;
            lfsr_q <= LFSR_SEED;
        end else begin
            if (bx_en)
                lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_MASK) : (lfsr_q >> 1);
            if (restart) begin
                gap_q <= '0;
                orb_q <= '0;
            end else if (bx_en) begin
                gap_q <= (gap_q == '0) ? rate : gap_q - 1'b1;
                if (at_slot)
                    orb_q <= (orb_q == '0) ? rate : orb_q - 1'b1;
            end
        end
    end

    a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/ltg_rule_filter.sv
module ltg_rule_filter
    import ltg_pkg::*;
#(
    parameter int AGE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bx_en,
    input  logic       issue,
    input  logic [1:0] rule_sel,
    output logic       ok
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    // age_q[k]: crossings since the (k+1)-th most recent accept, saturating
    logic [AGE_W-1:0] age_q [RULE_N];
    logic [RULE_N-1:0] pass;

    function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] v);
        return (v == AGE_MAX) ? v : v + 1'b1;
    endfunction

    for (genvar k = 0; k < RULE_N; k++) begin : g_age
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    age_q[k] <= AGE_MAX;
                else if (bx_en)
                    age_q[k] <= issue ? AGE_W'(1) : sat_inc(age_q[k]);
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)
                    age_q[k] <= AGE_MAX;
                else if (bx_en)
                    age_q[k] <= issue ? sat_inc(age_q[k-1]) : sat_inc(age_q[k]);
            end
        end
        assign pass[k] = ((k + int'(rule_sel)) >= RULE_N) ||
                         (age_q[k] >= AGE_W'(rule_window(k)));
    end

    assign ok = &pass;

    a_r6_history_order: assert property (@(posedge clk) disable iff (rst)
        age_q[0] <= age_q[1]);

endmodule

// File: rtl/ltrig_gen.sv
module ltrig_gen
    import ltg_pkg::*;
#(
    parameter int ORBIT_LEN  = 3564,
    parameter int ORBIT_SLOT = 500,
    parameter int BX_RATE    = 40_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bx_en,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_rules,
    input  logic [11:0] cfg_burst,
    input  logic [15:0] cfg_rate,
    input  logic        cmd_burst,
    input  logic        cmd_cont,
    input  logic        cmd_reset,
    output logic        l1a,
    output logic        cont_on
);
    localparam int IDX_W = $clog2(ORBIT_LEN);

    ltg_cfg_t         cfg;
    logic [IDX_W-1:0] bx_idx;
    logic [12:0]      remain_q;
    logic             pend_q, req, rule_ok, rules_on;
    logic             any_cmd, restart, active, issue;
    logic [1:0]       gap_sat;

    assign cfg = '{mode: ltg_mode_e'(cfg_mode), rules: cfg_rules,
                   burst: cfg_burst, rate: cfg_rate};

    ltg_timebase #(.ORBIT_LEN(ORBIT_LEN), .IDX_W(IDX_W)) i_tb (
        .clk(clk), .rst(rst), .bx_en(bx_en), .bx_idx(bx_idx));

    ltg_req_src #(.ORBIT_LEN(ORBIT_LEN), .ORBIT_SLOT(ORBIT_SLOT),
                  .BX_RATE(BX_RATE), .IDX_W(IDX_W)) i_req (
        .clk(clk), .rst(rst), .bx_en(bx_en), .restart(restart),
        .mode(cfg.mode), .rate(cfg.rate), .bx_idx(bx_idx), .req(req));

    ltg_rule_filter #(.AGE_W(8)) i_rules (
        .clk(clk), .rst(rst), .bx_en(bx_en), .issue(issue),
        .rule_sel(cfg.rules), .ok(rule_ok));

    always_comb begin
        any_cmd  = cmd_burst | cmd_cont | cmd_reset;
        restart  = cmd_burst | cmd_cont;
        active   = cont_on || (remain_q != '0);
        rules_on = rules_apply(cfg);
        issue    = bx_en && !any_cmd && active && (cfg.mode != MODE_IDLE) &&
                   (req || pend_q) && (!rules_on || rule_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_on  <= 1'b0;
            remain_q <= '0;
            pend_q   <= 1'b0;
            l1a      <= 1'b0;
        end else begin
            l1a <= issue;
            if (cmd_reset) begin
                cont_on  <= 1'b0;
                remain_q <= '0;
                pend_q   <= 1'b0;
            end else if (cmd_burst) begin
                cont_on  <= 1'b0;
                remain_q <= cont_on ? 13'd0 : {1'b0, cfg.burst} + 13'd1;
                pend_q   <= 1'b0;
            end else if (cmd_cont) begin
                cont_on  <= 1'b1;
                remain_q <= '0;
                pend_q   <= 1'b0;
            end else if (bx_en) begin
                pend_q <= active && (req || pend_q) && !issue;
                if (issue && !cont_on)
                    remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Independent crossing distance since the last accept, for the checks
    always_ff @(posedge clk) begin
        if (rst)
            gap_sat <= 2'd3;
        else if (bx_en)
            gap_sat <= issue ? 2'd1 : ((gap_sat == 2'd3) ? 2'd3 : gap_sat + 2'd1);
    end

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        l1a |=> !l1a);
    a_r11_after_crossing: assert property (@(posedge clk) disable iff (rst)
        l1a |-> $past(bx_en));
    a_r9_reset_stops: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (!cont_on && !l1a));
    a_r8_burst_clears_cont: assert property (@(posedge clk) disable iff (rst)
        (cmd_burst && !cmd_reset && cont_on) |=> !cont_on);
    a_r7_cont_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_cont && !cmd_burst && !cmd_reset) |=> cont_on);
    a_r10_idle_mode: assert property (@(posedge clk) disable iff (rst)
        (bx_en && cfg_mode == 2'b01) |=> !l1a);
    a_r2_no_spare_pulse: assert property (@(posedge clk) disable iff (rst)
        (remain_q == '0 && !cont_on) |=> !l1a);
    a_r6_rule1_spacing: assert property (@(posedge clk) disable iff (rst)
        (issue && rules_on) |-> (gap_sat == 2'd3));

endmodule

// File: tb/test_ltrig_gen.sv
module test_ltrig_gen;
    localparam int OL = 50;
    localparam int OS = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bx_en = 1'b0;
    logic [1:0]  cfg_mode = 2'b10;
    logic [1:0]  cfg_rules = 2'b00;
    logic [11:0] cfg_burst = '0;
    logic [15:0] cfg_rate = '0;
    logic        cmd_burst = 1'b0, cmd_cont = 1'b0, cmd_reset = 1'b0;
    logic        l1a, cont_on;

    always #5 clk = ~clk;

    ltrig_gen #(.ORBIT_LEN(OL), .ORBIT_SLOT(OS)) i_ltrig_gen (
        .clk(clk), .rst(rst), .bx_en(bx_en), .cfg_mode(cfg_mode),
        .cfg_rules(cfg_rules), .cfg_burst(cfg_burst), .cfg_rate(cfg_rate),
        .cmd_burst(cmd_burst), .cmd_cont(cmd_cont), .cmd_reset(cmd_reset),
        .l1a(l1a), .cont_on(cont_on));

    int n_chk = 0, n_err = 0;
    int xt [0:255];
    int exp_x [0:255];
    int n_x, n_exp, next_x, last_x, bad_spot, dbl;
    bit last_bx, prev_l1a, done;

    function automatic int win(input int i);
        return (i == 0) ? 3 : (i == 1) ? 25 : (i == 2) ? 100 : 240;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // One clock: sample the outputs, then drive the next inputs
    task automatic cyc(input bit bx, input bit cb, input bit cc, input bit cr);
        @(negedge clk);
        if (l1a) begin
            if (!last_bx) bad_spot++;
            if (prev_l1a) dbl++;
            if (n_x < 256) xt[n_x] = last_x;
            n_x++;
        end
        prev_l1a = l1a;
        bx_en = bx; cmd_burst = cb; cmd_cont = cc; cmd_reset = cr;
        if (bx) begin last_x = next_x; next_x++; end
        last_bx = bx;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bx_en = 1'b0; cmd_burst = 0; cmd_cont = 0; cmd_reset = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n_x = 0; next_x = 0; last_x = 0; last_bx = 0; prev_l1a = 0;
    endtask

    task automatic run_to(input int target, input bit gated);
        while (next_x < target) cyc(gated ? ($urandom % 4 != 0) : 1'b1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic build_exp(input int start, input bit orbit, input int n, input int rsel,
                             input bit ron, input int count, input int span);
        int h [0:3];
        bit pend, rq, ok;
        int fs;
        for (int i = 0; i < 4; i++) h[i] = -100000;
        pend = 0; n_exp = 0;
        fs = start + ((OS - (start % OL)) + OL) % OL;
        for (int x = start; x < start + span && n_exp < count; x++) begin
            if (orbit) rq = (x >= fs) && (x % OL == OS) && (((x - fs) / OL) % (n + 1) == 0);
            else       rq = ((x - start) % (n + 1) == 0);
            ok = 1;
            if (ron) for (int i = 0; i < 4 - rsel; i++) if (x - h[i] < win(i)) ok = 0;
            if ((rq || pend) && ok) begin
                if (n_exp < 256) exp_x[n_exp] = x;
                n_exp++;
                for (int i = 3; i > 0; i--) h[i] = h[i-1];
                h[0] = x; pend = 0;
            end else pend = pend || rq;
        end
    endtask

    task automatic cmp_sched(input string rq);
        chk(n_x == n_exp, {rq, " count"}, n_x, n_exp);
        for (int i = 0; i < n_exp && i < n_x && i < 256; i++)
            chk(xt[i] == exp_x[i], {rq, " crossing"}, xt[i], exp_x[i]);
    endtask

    task automatic check_rules(input int rsel, input string rq);
        int viol = 0;
        for (int i = 0; i < n_x && i < 256; i++)
            for (int r = 0; r < 4 - rsel; r++)
                if (i > r && (xt[i] - xt[i-r-1]) < win(r)) viol++;
        chk(viol == 0, rq, viol, 0);
    endtask

    task automatic setup(input logic [1:0] m, input logic [1:0] rs, input int b, input int n);
        cfg_mode = m; cfg_rules = rs; cfg_burst = 12'(b); cfg_rate = 16'(n);
    endtask

    initial begin
        int st, n, b, rs;
        void'($urandom(32'd4711));
        n_x = 0; next_x = 0; last_x = 0; bad_spot = 0; dbl = 0;

        // R1: reset state and no accepts without a command
        do_reset();
        cyc(0, 0, 0, 0);
        chk(l1a == 0, "R1 l1a after reset", int'(l1a), 0);
        chk(cont_on == 0, "R1 cont_on after reset", int'(cont_on), 0);
        setup(2'b10, 2'b00, 3, 0);
        run_to(40, 0);
        chk(n_x == 0, "R1 idle accepts", n_x, 0);

        // R3 / R2: crossing mode, N >= 63, burst of five
        do_reset(); setup(2'b10, 2'b00, 4, 70);
        cyc(0, 1, 0, 0); st = next_x;
        run_to(st + 400, 0);
        build_exp(st, 0, 70, 0, 0, 5, 400);
        cmp_sched("R3 R2 bx mode");

        // R3 / R11: random N, burst and rule field with gated crossings
        for (int it = 0; it < 3; it++) begin
            n = 63 + int'($urandom % 60); b = int'($urandom % 3); rs = int'($urandom % 4);
            do_reset(); setup(2'b10, 2'(rs), b, n);
            cyc(0, 1, 0, 0); st = next_x;
            run_to(st + (b + 1) * (n + 1) + 20, 1);
            build_exp(st, 0, n, rs, 0, b + 1, (b + 1) * (n + 1) + 20);
            cmp_sched("R3 R11 gated bx mode");
        end

        // R4 / R11: orbit mode every third orbit with gated crossings and wrap
        do_reset(); setup(2'b00, 2'b00, 2, 2);
        run_to(20, 1);
        cyc(0, 1, 0, 0); st = next_x;
        run_to(st + 420, 1);
        build_exp(st, 1, 2, 0, 0, 3, 420);
        cmp_sched("R4 orbit mode");

        // R6: every rule group with a request on every crossing
        for (int r = 0; r < 4; r++) begin
            do_reset(); setup(2'b10, 2'(r), 5, 0);
            cyc(0, 1, 0, 0); st = next_x;
            run_to(st + 800, 0);
            build_exp(st, 0, 0, r, 1, 6, 800);
            cmp_sched("R6 rule group");
        end

        // R6: deferral of a blocked request, N=1 under rule 1
        do_reset(); setup(2'b10, 2'b11, 3, 1);
        cyc(0, 1, 0, 0); st = next_x;
        run_to(st + 60, 0);
        build_exp(st, 0, 1, 3, 1, 4, 60);
        cmp_sched("R6 deferral");

        // R7 / R8: continuous run, then stop by a burst command
        do_reset(); setup(2'b10, 2'b11, 0, 9);
        cyc(0, 0, 1, 0); cyc(0, 0, 0, 0);
        chk(cont_on == 1, "R7 cont_on set", int'(cont_on), 1);
        st = next_x;
        run_to(st + 100, 0);
        build_exp(st, 0, 9, 3, 1, 10, 100);
        cmp_sched("R7 continuous");
        cyc(0, 1, 0, 0); cyc(0, 0, 0, 0);
        chk(cont_on == 0, "R8 cont_on cleared", int'(cont_on), 0);
        b = n_x;
        run_to(next_x + 60, 0);
        chk(n_x == b, "R8 no burst after stop", n_x, b);

        // R9: reset command stops continuous and burst runs
        cyc(0, 0, 1, 0);
        run_to(next_x + 20, 0);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
        chk(cont_on == 0, "R9 cont_on after reset cmd", int'(cont_on), 0);
        b = n_x;
        run_to(next_x + 60, 0);
        chk(n_x == b, "R9 no accepts after reset cmd", n_x, b);
        do_reset(); setup(2'b10, 2'b11, 10, 9);
        cyc(0, 1, 0, 0);
        run_to(next_x + 25, 0);
        cyc(0, 0, 0, 1);
        run_to(next_x + 100, 0);
        chk(n_x == 3, "R9 burst cut by reset cmd", n_x, 3);

        // R10: idle mode code
        do_reset(); setup(2'b01, 2'b00, 3, 0);
        cyc(0, 1, 0, 0);
        run_to(next_x + 300, 0);
        chk(n_x == 0, "R10 idle mode accepts", n_x, 0);

        // R12: simultaneous commands
        do_reset(); setup(2'b10, 2'b11, 1, 9);
        cyc(0, 1, 1, 0); cyc(0, 0, 0, 0);
        chk(cont_on == 0, "R12 burst beats cont", int'(cont_on), 0);
        run_to(next_x + 50, 0);
        chk(n_x == 2, "R12 burst count", n_x, 2);
        do_reset();
        cyc(0, 0, 1, 1); cyc(0, 0, 0, 0);
        chk(cont_on == 0, "R12 reset beats cont", int'(cont_on), 0);
        run_to(next_x + 50, 0);
        chk(n_x == 0, "R12 no accepts", n_x, 0);

        // R5: random mode, gated crossings, all rules
        do_reset(); setup(2'b11, 2'b00, 4, 60000);
        cyc(0, 1, 0, 0);
        run_to(next_x + 20000, 1);
        chk(n_x == 5, "R5 random burst count", n_x, 5);
        check_rules(0, "R5 R6 random rules 1-4");

        // R5: random mode, rules 1 and 2, longer burst
        do_reset(); setup(2'b11, 2'b10, 7, 65535);
        cyc(0, 1, 0, 0);
        run_to(next_x + 15000, 0);
        chk(n_x == 8, "R5 random burst count", n_x, 8);
        check_rules(2, "R5 R6 random rules 1-2");

        // R11: pulse placement over the whole run
        chk(bad_spot == 0, "R11 pulse after crossing", bad_spot, 0);
        chk(dbl == 0, "R11 single-cycle pulse", dbl, 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #1950000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule